// File: doc/BRIEF.md
# Zero-Gated Signed Byte Multiply-Accumulate Lane

This block is one lane of a wide SIMD array. Each lane holds a signed 8-bit weight, a signed 8-bit activation and a 32-bit accumulator. A shared opcode, broadcast to every lane, runs one operation per cycle on the registers the lane already holds. The operations are multiply-accumulate, plain multiply, add, subtract, copy-sign-to-mask, set-mask and masked zeroing. The weight comes from a byte-wide local memory read port. The activation comes from a neighbour-shift input. Both registers load in the same cycle when the load strobe is high.

Three mechanisms save power. A multiply-accumulate is suppressed whenever either held operand is zero, and an output flags each suppressed cycle. A weight load is skipped when the incoming byte equals the stored weight, and an output flags each real weight write. A rectified-linear step is done in two operations: copy the accumulator sign into the lane mask, then zero the accumulator in the lanes whose mask is set. A global enable is combined with the mask by AND. A separate clear input resets the accumulator and takes priority over the opcode.

Top module: `mac_lane`

## Requirements
- R1: After reset the accumulator, weight and activation are zero and the mask is 1.
- R2: Opcode 1 (MAC) adds the signed product of activation and weight to the accumulator in the next cycle. The sum wraps modulo 2^32.
- R3: For MAC, if the activation or the weight is zero, `gated` is 1 during that cycle and the accumulator keeps its value.
- R4: With `ld` high, the weight register is written, and `wt_wr` is 1, only when `mem_byte` differs from the stored weight. An equal byte leaves `wt_wr` at 0.
- R5: With `ld` high, the activation register takes `nbr_in` on the same edge as the weight load, even when the weight load is skipped.
- R6: Opcode 2 (MUL) replaces the accumulator with the signed product of activation and weight.
- R7: Opcode 3 (ADD) adds the sign-extended activation to the accumulator. Opcode 4 (SUB) subtracts it.
- R8: Opcode 5 (MSIGN) copies accumulator bit 31 into the mask. Opcode 6 (MSET) sets the mask to 1. Both act whatever the mask value is.
- R9: Opcode 7 (MZERO) zeroes the accumulator when the mask is 1. While the mask is 0, arithmetic, MZERO and loads change nothing.
- R10: `clr` zeroes the accumulator on the next edge, ignores the mask, and overrides the opcode in the same cycle.
- R11: With `lane_en` low, no register changes and `gated` and `wt_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_en | input | 1 | Global lane enable |
| op | input | 3 | Opcode (0 NOP, 1 MAC, 2 MUL, 3 ADD, 4 SUB, 5 MSIGN, 6 MSET, 7 MZERO) |
| clr | input | 1 | Accumulator clear, overrides the opcode |
| ld | input | 1 | Load weight and activation |
| mem_byte | input | 8 | Byte from the local memory read port |
| nbr_in | input | 8 | Activation from the neighbour shift path |
| acc_q | output | 32 | Accumulator |
| wt_q | output | 8 | Weight register |
| act_q | output | 8 | Activation register |
| mask_q | output | 1 | Lane condition mask |
| gated | output | 1 | MAC suppressed this cycle because an operand is zero |
| wt_wr | output | 1 | Weight register written this cycle |

## Verification
The hardest case to reach from the ports is accumulator wrap-around. Products are at most 2^14, so the accumulator can only be driven across 2^31 by a long run of multiply-accumulates. The stimulus loads -128 into both registers, holds MAC for 131072 cycles, and checks that the accumulator lands on 0x80000000 and then on 0x80004000. The masked path is reached by taking a positive accumulator through MSIGN, so that the mask becomes 0. The bench then checks that MZERO and a load have no effect until MSET restores the mask.

// File: rtl/mac_lane.sv
module mac_lane #(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lane_en,
  input  logic [2:0]           op,
  input  logic                 clr,
  input  logic                 ld,
  input  logic [DW-1:0]        mem_byte,
  input  logic [DW-1:0]        nbr_in,
  output logic [AW-1:0]        acc_q,
  output logic [DW-1:0]        wt_q,
  output logic [DW-1:0]        act_q,
  output logic                 mask_q,
  output logic                 gated,
  output logic                 wt_wr
);
  localparam int PW  = 2 * DW;
  localparam int EXT = AW - PW;
  localparam logic [2:0] OP_MAC = 3'd1, OP_MUL = 3'd2, OP_ADD = 3'd3, OP_SUB = 3'd4,
                         OP_MSIGN = 3'd5, OP_MSET = 3'd6, OP_MZERO = 3'd7;

  logic wr_ok, is_mac, is_mul, is_sub, arith, zero_opnd;
  logic signed [DW-1:0] mul_a, mul_b;
  logic signed [PW-1:0] prod;
  logic [AW-1:0] prod_x, base, sum;

  assign wr_ok  = lane_en & mask_q;
  assign is_mac = (op == OP_MAC);
  assign is_mul = (op == OP_MUL);
  assign is_sub = (op == OP_SUB);
  assign arith  = is_mac | is_mul | (op == OP_ADD) | is_sub;

  assign mul_a  = act_q;
  assign mul_b  = (is_mac | is_mul) ? wt_q : {{(DW-1){1'b0}}, 1'b1};
  assign prod   = mul_a * mul_b;
  assign prod_x = {{EXT{prod[PW-1]}}, prod};
  assign base   = is_mul ? '0 : acc_q;
  assign sum    = is_sub ? (base - prod_x) : (base + prod_x);

  assign zero_opnd = (act_q == '0) | (wt_q == '0);
  assign gated     = wr_ok & ~clr & is_mac & zero_opnd;
  assign wt_wr     = wr_ok & ld & (mem_byte != wt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      wt_q   <= '0;
      act_q  <= '0;
      mask_q <= 1'b1;
    end else if (lane_en) begin
      if (clr)
        acc_q <= '0;
      else if (wr_ok & arith & ~gated)
        acc_q <= sum;
      else if (wr_ok & (op == OP_MZERO))
        acc_q <= '0;

      if (!clr && op == OP_MSIGN)
        mask_q <= acc_q[AW-1];
      else if (!clr && op == OP_MSET)
        mask_q <= 1'b1;

      if (wr_ok & ld)
        act_q <= nbr_in;
      if (wt_wr)
        wt_q <= mem_byte;
    end
  end
endmodule

// File: rtl/mac_lane_chk.sv
module mac_lane_chk #(
  parameter int DW = 8,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lane_en,
  input logic [2:0]    op,
  input logic          clr,
  input logic          ld,
  input logic [DW-1:0] mem_byte,
  input logic [DW-1:0] nbr_in,
  input logic [AW-1:0] acc_q,
  input logic [DW-1:0] wt_q,
  input logic [DW-1:0] act_q,
  input logic          mask_q,
  input logic          gated,
  input logic          wt_wr
);
  // R3
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gated |=> $stable(acc_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |=> ($stable(acc_q) && $stable(wt_q) && $stable(act_q) && $stable(mask_q)));

  // R11
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_en |-> (!gated && !wt_wr));

  // R4
  skip_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && mem_byte == wt_q) |-> !wt_wr);

  // R4
  wt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wt_wr |=> (wt_q == $past(mem_byte)));

  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && clr) |=> (acc_q == '0));

  // R8
  msign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && !clr && op == 3'd5) |=> (mask_q == $past(acc_q[AW-1])));

  // R9
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_en && !mask_q && !clr) |=> ($stable(acc_q) && $stable(wt_q) && $stable(act_q)));
endmodule

bind mac_lane mac_lane_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lane_en(lane_en), .op(op), .clr(clr), .ld(ld),
  .mem_byte(mem_byte), .nbr_in(nbr_in), .acc_q(acc_q), .wt_q(wt_q), .act_q(act_q),
  .mask_q(mask_q), .gated(gated), .wt_wr(wt_wr)
);

// File: tb/tb_mac_lane.sv
module tb_mac_lane;
  logic clk = 1'b0, rst_n = 1'b0, lane_en = 1'b0, clr = 1'b0, ld = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] mem_byte = 8'd0, nbr_in = 8'd0;
  logic [31:0] acc_q;
  logic [7:0] wt_q, act_q;
  logic mask_q, gated, wt_wr;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  mac_lane dut (.clk(clk), .rst_n(rst_n), .lane_en(lane_en), .op(op), .clr(clr), .ld(ld),
    .mem_byte(mem_byte), .nbr_in(nbr_in), .acc_q(acc_q), .wt_q(wt_q), .act_q(act_q),
    .mask_q(mask_q), .gated(gated), .wt_wr(wt_wr));

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    op = 3'd0; ld = 1'b0; clr = 1'b0; lane_en = 1'b1;
  endtask

  task automatic do_op(input logic [2:0] o);
    op = o; @(negedge clk); idle();
  endtask

  task automatic load(input logic [7:0] w, input logic [7:0] a, input bit exp_wr);
    ld = 1'b1; mem_byte = w; nbr_in = a; #1;
    chk(wt_wr == exp_wr, "R4 wt_wr flag", 32'(wt_wr), 32'(exp_wr));
    @(negedge clk); idle();
    chk(wt_q == w, "R4 weight value", 32'(wt_q), 32'(w));
    chk(act_q == a, "R5 activation value", 32'(act_q), 32'(a));
  endtask

  task automatic t_reset();
    chk(acc_q == 0, "R1 acc reset", acc_q, 0);
    chk(wt_q == 0 && act_q == 0, "R1 regs reset", {wt_q, act_q}, 0);
    chk(mask_q == 1'b1, "R1 mask reset", 32'(mask_q), 1);
  endtask

  task automatic t_mac();
    load(8'd3, -8'sd4, 1'b1);
    do_op(3'd1);
    chk(acc_q == -32'sd12, "R2 mac first", acc_q, -32'sd12);
    do_op(3'd1);
    chk(acc_q == -32'sd24, "R2 mac second", acc_q, -32'sd24);
    load(-8'sd7, -8'sd5, 1'b1);
    do_op(3'd1);
    chk(acc_q == 32'sd11, "R2 mac neg*neg", acc_q, 32'sd11);
  endtask

  task automatic t_gate();
    load(8'd0, 8'd5, 1'b1);
    op = 3'd1; #1;
    chk(gated == 1'b1, "R3 gated zero weight", 32'(gated), 1);
    @(negedge clk); idle();
    chk(acc_q == 32'sd11, "R3 acc held zero weight", acc_q, 32'sd11);
    load(8'd9, 8'd0, 1'b1);
    op = 3'd1; #1;
    chk(gated == 1'b1, "R3 gated zero act", 32'(gated), 1);
    @(negedge clk); idle();
    chk(acc_q == 32'sd11, "R3 acc held zero act", acc_q, 32'sd11);
  endtask

  task automatic t_skip();
    load(8'd9, 8'd2, 1'b0);
    load(8'd9, 8'd4, 1'b0);
    load(8'd10, 8'd4, 1'b1);
  endtask

  task automatic t_arith();
    load(8'd6, -8'sd3, 1'b1);
    do_op(3'd2);
    chk(acc_q == -32'sd18, "R6 mul", acc_q, -32'sd18);
    do_op(3'd3);
    chk(acc_q == -32'sd21, "R7 add", acc_q, -32'sd21);
    do_op(3'd4);
    do_op(3'd4);
    chk(acc_q == -32'sd15, "R7 sub", acc_q, -32'sd15);
  endtask

  task automatic t_relu();
    do_op(3'd5);
    chk(mask_q == 1'b1, "R8 msign negative", 32'(mask_q), 1);
    do_op(3'd7);
    chk(acc_q == 0, "R9 mzero clears", acc_q, 0);
    load(8'd5, 8'd7, 1'b1);
    do_op(3'd1);
    chk(acc_q == 32'sd35, "R2 mac positive", acc_q, 32'sd35);
    do_op(3'd5);
    chk(mask_q == 1'b0, "R8 msign positive", 32'(mask_q), 0);
    do_op(3'd7);
    chk(acc_q == 32'sd35, "R9 mzero masked off", acc_q, 32'sd35);
    ld = 1'b1; mem_byte = 8'd77; nbr_in = 8'd66; #1;
    chk(wt_wr == 1'b0, "R9 no weight write masked", 32'(wt_wr), 0);
    @(negedge clk); idle();
    chk(wt_q == 8'd5 && act_q == 8'd7, "R9 loads blocked", {wt_q, act_q}, {8'd5, 8'd7});
    do_op(3'd1);
    chk(acc_q == 32'sd35, "R9 mac blocked", acc_q, 32'sd35);
    do_op(3'd6);
    chk(mask_q == 1'b1, "R8 mset", 32'(mask_q), 1);
  endtask

  task automatic t_clr();
    clr = 1'b1; op = 3'd1; #1;
    chk(gated == 1'b0, "R10 no gate flag on clr", 32'(gated), 0);
    @(negedge clk); idle();
    chk(acc_q == 0, "R10 clr beats mac", acc_q, 0);
    do_op(3'd1);
    do_op(3'd5);
    chk(mask_q == 1'b0, "R8 mask off before clr", 32'(mask_q), 0);
    clr = 1'b1; @(negedge clk); idle();
    chk(acc_q == 0, "R10 clr ignores mask", acc_q, 0);
    do_op(3'd6);
  endtask

  task automatic t_disable();
    load(8'd2, 8'd3, 1'b1);
    do_op(3'd1);
    lane_en = 1'b0; op = 3'd1; ld = 1'b1; mem_byte = 8'd50; nbr_in = 8'd51; #1;
    chk(wt_wr == 1'b0 && gated == 1'b0, "R11 flags low", {wt_wr, gated}, 0);
    @(negedge clk);
    clr = 1'b1; op = 3'd5; @(negedge clk); idle();
    chk(acc_q == 32'sd6, "R11 acc frozen", acc_q, 32'sd6);
    chk(wt_q == 8'd2 && act_q == 8'd3 && mask_q, "R11 regs frozen",
        {wt_q, act_q, 7'd0, mask_q}, {8'd2, 8'd3, 8'd1});
  endtask

  task automatic t_wrap();
    clr = 1'b1; @(negedge clk); idle();
    load(8'h80, 8'h80, 1'b1);
    op = 3'd1;
    repeat (131072) @(negedge clk);
    idle();
    chk(acc_q == 32'h8000_0000, "R2 wrap to min", acc_q, 32'h8000_0000);
    do_op(3'd1);
    chk(acc_q == 32'h8000_4000, "R2 past wrap", acc_q, 32'h8000_4000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk); idle();
    t_mac();
    t_gate();
    t_skip();
    t_arith();
    t_relu();
    t_clr();
    t_disable();
    t_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule